// File: doc/BRIEF.md
# JTAG Scan Chain Router

This block is a purely combinational router that sits between two possible JTAG masters and eight device scan chains on a board. One master is a local pin header. The other is a remote controller that arrives over a cable. A static source switch chooses which master is active, and only that master sees the returned test data.

The block has two routing modes. In single mode, one chain, chosen by a three-bit index switch, is connected straight to the active master. In daisy mode, any subset of the chains, chosen by an eight-bit mask switch, is joined into one scan path. The chains are joined in ascending index order, and the last enabled chain's TDO returns to the master. Any chain that is not enabled is parked so that it stays in its Test-Logic-Reset state.

The chains are split across two I/O voltage groups. Chains 0 to 5 use the group A ports and chains 6 and 7 use the group B ports. The block does no level translation. It holds no clocked state, so every output follows its inputs within the same cycle.

Top module: `jtag_chain_router`

## Requirements
- R1: When `sw_remote` is 0, the header master (`hdr_tck`, `hdr_tms`) drives TCK and TMS of every enabled chain. When `sw_remote` is 1, the cable master (`cab_tck`, `cab_tms`) drives them.
- R2: When `sw_daisy` is 0 (single mode), only chain `sw_chain_sel` is enabled and `sw_chain_mask` has no effect. The enabled chain's TDI equals the active master's TDI.
- R3: When `sw_daisy` is 1 (daisy mode), chain i is enabled exactly when bit i of `sw_chain_mask` is 1, and `sw_chain_sel` has no effect. The lowest enabled chain takes the master's TDI. Each later enabled chain takes the TDO of the nearest lower enabled chain.
- R4: The TDO of the highest enabled chain is returned on the active master's TDO output.
- R5: Every chain that is not enabled sees TCK held at 0, TMS held at 1 and TDI held at 1.
- R6: The TDO output of the master that is not selected is held at constant 1.
- R7: In daisy mode with an all-zero mask, the active master's TDO equals its own TDI.
- R8: The block has no clock and no state. Every output reflects the current inputs in the same cycle that the inputs change.
- R9: Chain index i maps to bit i of the group A ports for i from 0 to 5, and to bit i-6 of the group B ports for i of 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hdr_tck | input | 1 | Header master test clock |
| hdr_tms | input | 1 | Header master mode select |
| hdr_tdi | input | 1 | Header master data into the scan path |
| hdr_tdo | output | 1 | Data returned to the header master |
| cab_tck | input | 1 | Cable master test clock |
| cab_tms | input | 1 | Cable master mode select |
| cab_tdi | input | 1 | Cable master data into the scan path |
| cab_tdo | output | 1 | Data returned to the cable master |
| sw_remote | input | 1 | Source switch: 0 selects the header, 1 selects the cable |
| sw_daisy | input | 1 | Mode switch: 0 selects single chain, 1 selects daisy chain |
| sw_chain_sel | input | 3 | Chain index used in single mode |
| sw_chain_mask | input | 8 | Chain enable mask used in daisy mode, bit i for chain i |
| grp_a_tck | output | 6 | TCK to chains 0 to 5 |
| grp_a_tms | output | 6 | TMS to chains 0 to 5 |
| grp_a_tdi | output | 6 | TDI to chains 0 to 5 |
| grp_a_tdo | input | 6 | TDO from chains 0 to 5 |
| grp_b_tck | output | 2 | TCK to chains 6 and 7 |
| grp_b_tms | output | 2 | TMS to chains 6 and 7 |
| grp_b_tdi | output | 2 | TDI to chains 6 and 7 |
| grp_b_tdo | input | 2 | TDO from chains 6 and 7 |

## Verification
The assertions rely on two facts about the inputs. The switches are static while a result is observed, and the single-mode index always names an existing chain, so exactly one chain is enabled in that mode. They also assume every input holds a defined level, because the checks compare settled combinational values rather than transitions.

The stimulus keeps to these assumptions. It changes switches and pin levels only just after a rising clock edge and samples the outputs on the following falling edge, once everything has settled. Its index values are taken from the 0 to 7 range. Each item varies the chain TDO patterns and the master TDI level, so that a mis-stitched path or a swapped master shows up on a specific pin.

// File: rtl/jtag_route_pkg.sv
package jtag_route_pkg;

    localparam int DEF_GRP_A_CHAINS = 6;
    localparam int DEF_GRP_B_CHAINS = 2;

    typedef enum logic {
        SRC_HEADER = 1'b0,
        SRC_CABLE  = 1'b1
    } src_e;

    typedef enum logic {
        ROUTE_SINGLE = 1'b0,
        ROUTE_DAISY  = 1'b1
    } route_e;

    typedef struct packed {
        logic tck;
        logic tms;
        logic tdi;
    } jtag_fwd_t;

    localparam logic PARK_TDO = 1'b1;

    // Levels that keep an unused chain in Test-Logic-Reset.
    function automatic jtag_fwd_t park_fwd();
        jtag_fwd_t p;
        p.tck = 1'b0;
        p.tms = 1'b1;
        p.tdi = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/jtag_src_mux.sv
module jtag_src_mux
    import jtag_route_pkg::*;
(
    input  src_e      src,
    input  jtag_fwd_t hdr_fwd,
    input  jtag_fwd_t cab_fwd,
    input  logic      ret_tdo,
    output jtag_fwd_t mst_fwd,
    output logic      hdr_tdo,
    output logic      cab_tdo
);

    always_comb begin
        if (src == SRC_CABLE) begin
            mst_fwd = cab_fwd;
            hdr_tdo = PARK_TDO;
            cab_tdo = ret_tdo;
        end else begin
            mst_fwd = hdr_fwd;
            hdr_tdo = ret_tdo;
            cab_tdo = PARK_TDO;
        end
    end

endmodule

// File: rtl/jtag_enable_decode.sv
module jtag_enable_decode
    import jtag_route_pkg::*;
#(
    parameter int NUM_CHAINS = 8,
    parameter int SEL_W      = 3
) (
    input  route_e                route,
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_CHAINS-1:0] mask,
    output logic [NUM_CHAINS-1:0] en
);

    logic [NUM_CHAINS-1:0] onehot;

    for (genvar gi = 0; gi < NUM_CHAINS; gi++) begin : g_dec
        assign onehot[gi] = (sel == SEL_W'(gi));
    end

    assign en = (route == ROUTE_DAISY) ? mask : onehot;

endmodule

// File: rtl/jtag_scan_stitch.sv
module jtag_scan_stitch
    import jtag_route_pkg::*;
#(
    parameter int NUM_CHAINS = 8
) (
    input  jtag_fwd_t             mst_fwd,
    input  logic [NUM_CHAINS-1:0] en,
    input  logic [NUM_CHAINS-1:0] ch_tdo,
    output logic [NUM_CHAINS-1:0] ch_tck,
    output logic [NUM_CHAINS-1:0] ch_tms,
    output logic [NUM_CHAINS-1:0] ch_tdi,
    output logic                  ret_tdo
);

    localparam jtag_fwd_t PARK = park_fwd();

    // path[i] is the scan data arriving at stage i; an idle stage passes it on.
    logic path [NUM_CHAINS+1];

    assign path[0] = mst_fwd.tdi;

    for (genvar gi = 0; gi < NUM_CHAINS; gi++) begin : g_stage
        assign ch_tck[gi]   = en[gi] ? mst_fwd.tck : PARK.tck;
        assign ch_tms[gi]   = en[gi] ? mst_fwd.tms : PARK.tms;
        assign ch_tdi[gi]   = en[gi] ? path[gi]    : PARK.tdi;
        assign path[gi + 1] = en[gi] ? ch_tdo[gi]  : path[gi];
    end

    assign ret_tdo = path[NUM_CHAINS];

endmodule

// File: rtl/jtag_chain_router.sv
module jtag_chain_router
    import jtag_route_pkg::*;
#(
    parameter int GRP_A_CHAINS = DEF_GRP_A_CHAINS,
    parameter int GRP_B_CHAINS = DEF_GRP_B_CHAINS,
    parameter int SEL_W        = $clog2(GRP_A_CHAINS + GRP_B_CHAINS)
) (
    input  logic                                 hdr_tck,
    input  logic                                 hdr_tms,
    input  logic                                 hdr_tdi,
    output logic                                 hdr_tdo,
    input  logic                                 cab_tck,
    input  logic                                 cab_tms,
    input  logic                                 cab_tdi,
    output logic                                 cab_tdo,
    input  logic                                 sw_remote,
    input  logic                                 sw_daisy,
    input  logic [SEL_W-1:0]                     sw_chain_sel,
    input  logic [GRP_A_CHAINS+GRP_B_CHAINS-1:0] sw_chain_mask,
    output logic [GRP_A_CHAINS-1:0]              grp_a_tck,
    output logic [GRP_A_CHAINS-1:0]              grp_a_tms,
    output logic [GRP_A_CHAINS-1:0]              grp_a_tdi,
    input  logic [GRP_A_CHAINS-1:0]              grp_a_tdo,
    output logic [GRP_B_CHAINS-1:0]              grp_b_tck,
    output logic [GRP_B_CHAINS-1:0]              grp_b_tms,
    output logic [GRP_B_CHAINS-1:0]              grp_b_tdi,
    input  logic [GRP_B_CHAINS-1:0]              grp_b_tdo
);

    localparam int NUM_CHAINS = GRP_A_CHAINS + GRP_B_CHAINS;

    jtag_fwd_t             hdr_fwd;
    jtag_fwd_t             cab_fwd;
    jtag_fwd_t             mst_fwd;
    logic                  ret_tdo;
    logic [NUM_CHAINS-1:0] chain_en;
    logic [NUM_CHAINS-1:0] ch_tck;
    logic [NUM_CHAINS-1:0] ch_tms;
    logic [NUM_CHAINS-1:0] ch_tdi;
    logic [NUM_CHAINS-1:0] ch_tdo;

    assign hdr_fwd = '{tck: hdr_tck, tms: hdr_tms, tdi: hdr_tdi};
    assign cab_fwd = '{tck: cab_tck, tms: cab_tms, tdi: cab_tdi};

    jtag_src_mux u_src (
        .src     (src_e'(sw_remote)),
        .hdr_fwd (hdr_fwd),
        .cab_fwd (cab_fwd),
        .ret_tdo (ret_tdo),
        .mst_fwd (mst_fwd),
        .hdr_tdo (hdr_tdo),
        .cab_tdo (cab_tdo)
    );

    jtag_enable_decode #(
        .NUM_CHAINS (NUM_CHAINS),
        .SEL_W      (SEL_W)
    ) u_dec (
        .route (route_e'(sw_daisy)),
        .sel   (sw_chain_sel),
        .mask  (sw_chain_mask),
        .en    (chain_en)
    );

    jtag_scan_stitch #(
        .NUM_CHAINS (NUM_CHAINS)
    ) u_stitch (
        .mst_fwd (mst_fwd),
        .en      (chain_en),
        .ch_tdo  (ch_tdo),
        .ch_tck  (ch_tck),
        .ch_tms  (ch_tms),
        .ch_tdi  (ch_tdi),
        .ret_tdo (ret_tdo)
    );

    // Voltage-group split (R9): low indices to group A, the rest to group B.
    assign ch_tdo    = {grp_b_tdo, grp_a_tdo};
    assign grp_a_tck = ch_tck[GRP_A_CHAINS-1:0];
    assign grp_a_tms = ch_tms[GRP_A_CHAINS-1:0];
    assign grp_a_tdi = ch_tdi[GRP_A_CHAINS-1:0];
    assign grp_b_tck = ch_tck[NUM_CHAINS-1:GRP_A_CHAINS];
    assign grp_b_tms = ch_tms[NUM_CHAINS-1:GRP_A_CHAINS];
    assign grp_b_tdi = ch_tdi[NUM_CHAINS-1:GRP_A_CHAINS];

endmodule

// File: rtl/jtag_chain_router_chk.sv
module jtag_chain_router_chk #(
    parameter int GRP_A_CHAINS = 6,
    parameter int GRP_B_CHAINS = 2,
    parameter int SEL_W        = 3
) (
    input logic                                 hdr_tck,
    input logic                                 hdr_tms,
    input logic                                 hdr_tdi,
    input logic                                 hdr_tdo,
    input logic                                 cab_tck,
    input logic                                 cab_tms,
    input logic                                 cab_tdi,
    input logic                                 cab_tdo,
    input logic                                 sw_remote,
    input logic                                 sw_daisy,
    input logic [SEL_W-1:0]                     sw_chain_sel,
    input logic [GRP_A_CHAINS+GRP_B_CHAINS-1:0] sw_chain_mask,
    input logic [GRP_A_CHAINS+GRP_B_CHAINS-1:0] chain_en,
    input logic [GRP_A_CHAINS+GRP_B_CHAINS-1:0] ch_tck,
    input logic [GRP_A_CHAINS+GRP_B_CHAINS-1:0] ch_tms,
    input logic [GRP_A_CHAINS+GRP_B_CHAINS-1:0] ch_tdi
);

    localparam int NUM_CHAINS = GRP_A_CHAINS + GRP_B_CHAINS;

    logic act_tck;
    logic act_tms;
    logic act_tdi;
    logic act_tdo;

    assign act_tck = sw_remote ? cab_tck : hdr_tck;
    assign act_tms = sw_remote ? cab_tms : hdr_tms;
    assign act_tdi = sw_remote ? cab_tdi : hdr_tdi;
    assign act_tdo = sw_remote ? cab_tdo : hdr_tdo;

    always_comb begin
        for (int i = 0; i < NUM_CHAINS; i++) begin
            if (!chain_en[i]) begin
                assert_idle_parked_R5: assert (ch_tck[i] == 1'b0 && ch_tms[i] == 1'b1 && ch_tdi[i] == 1'b1)
                    else $error("chain %0d not parked", i);
            end else begin
                assert_master_drive_R1: assert (ch_tck[i] == act_tck && ch_tms[i] == act_tms)
                    else $error("chain %0d not driven by active master", i);
            end
        end
        if (sw_remote) begin
            assert_hdr_tdo_idle_R6: assert (hdr_tdo == 1'b1) else $error("header TDO not idle");
        end else begin
            assert_cab_tdo_idle_R6: assert (cab_tdo == 1'b1) else $error("cable TDO not idle");
        end
        if (!sw_daisy && int'(sw_chain_sel) < NUM_CHAINS) begin
            assert_single_onehot_R2: assert ($onehot(chain_en)) else $error("single mode not one-hot");
        end
        if (sw_daisy && sw_chain_mask == '0) begin
            assert_empty_loop_R7: assert (act_tdo == act_tdi) else $error("empty path not looped back");
        end
    end

endmodule

bind jtag_chain_router jtag_chain_router_chk #(
    .GRP_A_CHAINS (GRP_A_CHAINS),
    .GRP_B_CHAINS (GRP_B_CHAINS),
    .SEL_W        (SEL_W)
) u_chk (.*);

// File: tb/jtag_chain_router_tb.sv
module jtag_chain_router_tb;

    typedef struct {
        string      tag;
        logic       hdr_tdo;
        logic       cab_tdo;
        logic [7:0] tck;
        logic [7:0] tms;
        logic [7:0] tdi;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic       hdr_tck = 0, hdr_tms = 0, hdr_tdi = 0;
    logic       cab_tck = 0, cab_tms = 0, cab_tdi = 0;
    logic       sw_remote = 0, sw_daisy = 0;
    logic [2:0] sw_chain_sel = 0;
    logic [7:0] sw_chain_mask = 0;
    logic [7:0] ch_tdo = 0;
    logic       hdr_tdo, cab_tdo;
    logic [5:0] grp_a_tck, grp_a_tms, grp_a_tdi;
    logic [1:0] grp_b_tck, grp_b_tms, grp_b_tdi;

    int tests = 0;
    int fails = 0;
    exp_t q[$];

    jtag_chain_router u_dut (
        .hdr_tck (hdr_tck), .hdr_tms (hdr_tms), .hdr_tdi (hdr_tdi), .hdr_tdo (hdr_tdo),
        .cab_tck (cab_tck), .cab_tms (cab_tms), .cab_tdi (cab_tdi), .cab_tdo (cab_tdo),
        .sw_remote (sw_remote), .sw_daisy (sw_daisy),
        .sw_chain_sel (sw_chain_sel), .sw_chain_mask (sw_chain_mask),
        .grp_a_tck (grp_a_tck), .grp_a_tms (grp_a_tms), .grp_a_tdi (grp_a_tdi),
        .grp_a_tdo (ch_tdo[5:0]),
        .grp_b_tck (grp_b_tck), .grp_b_tms (grp_b_tms), .grp_b_tdi (grp_b_tdi),
        .grp_b_tdo (ch_tdo[7:6])
    );

    // Expected values built from the requirements.
    function automatic exp_t model(string tag);
        exp_t       e;
        logic [7:0] en;
        logic       m_tck, m_tms, path;
        en    = sw_daisy ? sw_chain_mask : (8'b1 << sw_chain_sel);
        m_tck = sw_remote ? cab_tck : hdr_tck;
        m_tms = sw_remote ? cab_tms : hdr_tms;
        path  = sw_remote ? cab_tdi : hdr_tdi;
        e.tag = tag;
        for (int i = 0; i < 8; i++) begin
            if (en[i]) begin
                e.tck[i] = m_tck;
                e.tms[i] = m_tms;
                e.tdi[i] = path;
                path     = ch_tdo[i];
            end else begin
                e.tck[i] = 1'b0;
                e.tms[i] = 1'b1;
                e.tdi[i] = 1'b1;
            end
        end
        e.hdr_tdo = sw_remote ? 1'b1 : path;
        e.cab_tdo = sw_remote ? path : 1'b1;
        return e;
    endfunction

    task automatic apply(input string tag, input logic remote, input logic daisy,
                         input logic [2:0] sel, input logic [7:0] mask,
                         input logic [2:0] hdr, input logic [2:0] cab,
                         input logic [7:0] tdo_pat);
        @(posedge clk);
        #1;
        sw_remote     = remote;
        sw_daisy      = daisy;
        sw_chain_sel  = sel;
        sw_chain_mask = mask;
        {hdr_tck, hdr_tms, hdr_tdi} = hdr;
        {cab_tck, cab_tms, cab_tdi} = cab;
        ch_tdo        = tdo_pat;
        q.push_back(model(tag));
    endtask

    task automatic cmp1(string tag, string what, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic cmp8(string tag, string what, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Monitor: outputs settle combinationally; compare mid-cycle.
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp1(e.tag, "hdr_tdo", hdr_tdo, e.hdr_tdo);
            cmp1(e.tag, "cab_tdo", cab_tdo, e.cab_tdo);
            cmp8(e.tag, "tck", {grp_b_tck, grp_a_tck}, e.tck);
            cmp8(e.tag, "tms", {grp_b_tms, grp_a_tms}, e.tms);
            cmp8(e.tag, "tdi", {grp_b_tdi, grp_a_tdi}, e.tdi);
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Default switches: header, single mode, chain 0 (R2 reset state).
        apply("R2", 0, 0, 3'd0, 8'h00, 3'b001, 3'b000, 8'h00);
        apply("R2", 0, 0, 3'd0, 8'h00, 3'b110, 3'b000, 8'h01);
        // Group B mapping (R9).
        apply("R9", 0, 0, 3'd7, 8'h00, 3'b101, 3'b010, 8'h80);
        apply("R9", 0, 0, 3'd6, 8'h00, 3'b110, 3'b010, 8'h00);
        apply("R9", 0, 0, 3'd5, 8'h00, 3'b111, 3'b000, 8'hDF);
        // Cable master selected (R1, R6).
        apply("R1", 1, 0, 3'd3, 8'h00, 3'b000, 3'b111, 8'h08);
        apply("R6", 1, 0, 3'd3, 8'h00, 3'b111, 3'b100, 8'h00);
        // Mask ignored in single mode (R2).
        apply("R2", 0, 0, 3'd2, 8'hFF, 3'b110, 3'b000, 8'hAA);
        // Daisy stitching, ascending order (R3, R4).
        apply("R3", 0, 1, 3'd0, 8'hA5, 3'b110, 3'b000, 8'h5A);
        apply("R4", 0, 1, 3'd0, 8'h81, 3'b111, 3'b000, 8'h01);
        apply("R4", 1, 1, 3'd4, 8'hFF, 3'b000, 3'b111, 8'h6C);
        apply("R3", 1, 1, 3'd7, 8'h42, 3'b000, 3'b110, 8'hBD);
        // Parked chains while the master toggles (R5).
        apply("R5", 0, 1, 3'd0, 8'h10, 3'b011, 3'b000, 8'hEF);
        apply("R5", 1, 0, 3'd1, 8'h00, 3'b000, 3'b010, 8'hFD);
        // Empty daisy selection loops back (R7).
        apply("R7", 0, 1, 3'd5, 8'h00, 3'b111, 3'b000, 8'hFF);
        apply("R7", 0, 1, 3'd5, 8'h00, 3'b110, 3'b000, 8'hFF);
        apply("R7", 1, 1, 3'd2, 8'h00, 3'b000, 3'b110, 8'h00);
        // Same-cycle response to a TDO change alone (R8).
        apply("R8", 0, 1, 3'd0, 8'h0F, 3'b100, 3'b000, 8'h00);
        apply("R8", 0, 1, 3'd0, 8'h0F, 3'b100, 3'b000, 8'h08);
        apply("R8", 1, 0, 3'd4, 8'h0F, 3'b000, 3'b101, 8'h10);
        @(posedge clk);
        @(negedge clk);
        #1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule